// File: doc/BRIEF.md
# Indexed Effective-Address Generator

This block is the address-mode unit of a small processor with 16-bit addresses and 8-bit data. When `start` is pulsed, it reads the operand bytes that follow the opcode and builds the effective address for the selected addressing mode. Those bytes come through a port that performs one read per cycle. The read data is combinational: it is sampled on the clock edge that ends the cycle in which `rd_en` is high. The modes are absolute, absolute indexed by X or Y, zero page, zero page indexed, pre-indexed indirect, post-indexed indirect and relative branch.

When an indirect mode needs pointer bytes, the unit fetches them from page zero. When indexing needs a dummy access, the unit issues it at the uncorrected address. The caller supplies the access kind: a plain read, or a write / read-modify-write. The kind decides whether an indexed access that crosses a page costs a cycle, or always issues the dummy read.

When the work is complete, `done` is high for one cycle. In that cycle `ea` holds the final address, `extra` holds the penalty cycles (0 to 2) and `next_pc` holds the address after the operand bytes. Opcode decoding and execution belong to the surrounding core.

Top module: `ea_gen`

## Requirements
- R1: After a synchronous reset, `done`, `rd_en` and `extra` are all 0.
- R2: Absolute mode (code 0) reads `pc`, then `pc+1`. It gives `ea` = {second byte, first byte}, `extra` = 0 and `next_pc` = `pc+2`. `done` rises one cycle after the last read.
- R3: For absolute-indexed reads (code 1 adds X, code 2 adds Y, `wr_kind` = 0), no dummy read occurs and `extra` is 0 when the high byte does not change.
- R4: For indexed reads whose index carries into the high byte, one dummy read is issued at {base high byte, sum low byte} and `extra` is 1.
- R5: For indexed accesses with `wr_kind` = 1, the dummy read at {base high byte, sum low byte} always happens and `extra` is 0.
- R6: Zero-page modes (code 3 plain, code 4 +X, code 5 +Y) read only `pc`. They give `ea` = {0x00, (byte + index) mod 256} and `next_pc` = `pc+1`.
- R7: Pre-indexed indirect mode (code 6) reads the pointer byte p. It then reads {0x00,(p+X) mod 256} as the low byte and {0x00,(p+X+1) mod 256} as the high byte. Both bytes form `ea` with `extra` 0.
- R8: Post-indexed indirect mode (code 7) reads {0x00,p} as the low byte and {0x00,(p+1) mod 256} as the high byte, then adds Y under the rules of R3, R4 and R5.
- R9: Relative mode (code 8) reads one signed displacement. When `br_taken` = 0, `ea` = `pc+1` and `extra` = 0. When it is 1, `ea` = `pc+1`+displacement. In that case `extra` is 2 if the high byte differs from that of `pc+1`, and 1 otherwise.
- R10: Every 16-bit sum wraps modulo 65536.
- R11: `done` lasts exactly one cycle, and `start` has no effect while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (taken when idle) |
| mode | input | 4 | Addressing mode code |
| wr_kind | input | 1 | 1 = write or read-modify-write, 0 = read |
| br_taken | input | 1 | Branch condition result for relative mode |
| pc | input | 16 | Address of the first operand byte |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| rd_en | output | 1 | Read request this cycle |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data for the current request |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| extra | output | 2 | Extra cycle count |
| next_pc | output | 16 | Address following the operand bytes |

## Verification
The index carry out of the low byte and the wrap of the full 16-bit sum can occur together. Absolute X with base 0xFFF0 and X = 0x20 is one such case. The bench checks that the dummy read lands at 0xFF10, that `ea` wraps to 0x0010 and that the read penalty is still counted. A second pairing is the zero-page pointer wrap and the Y carry in post-indexed mode. A pointer at 0xFF must take its high byte from 0x0000, and the following +Y must then cross a page, so the bench checks the whole read sequence and the penalty in one operation.

// File: rtl/eag_pkg.sv
package eag_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef enum logic [3:0] {
        M_ABS = 4'd0, M_ABX = 4'd1, M_ABY = 4'd2,
        M_ZP  = 4'd3, M_ZPX = 4'd4, M_ZPY = 4'd5,
        M_IZX = 4'd6, M_IZY = 4'd7, M_REL = 4'd8
    } amode_t;

    typedef enum logic [2:0] {
        S_IDLE, S_OPLO, S_OPHI, S_PTRLO, S_PTRHI, S_FIX, S_DONE
    } st_t;

    function automatic logic picks_y(amode_t m);
        return (m == M_ABY) || (m == M_ZPY) || (m == M_IZY);
    endfunction

    function automatic logic wide_indexed(amode_t m);
        return (m == M_ABX) || (m == M_ABY) || (m == M_IZY);
    endfunction

    function automatic logic page_zero_mode(amode_t m);
        return (m == M_ZP) || (m == M_ZPX) || (m == M_ZPY);
    endfunction

    function automatic logic [ADDR_W-1:0] sext(logic [DATA_W-1:0] d);
        return {{(ADDR_W-DATA_W){d[DATA_W-1]}}, d};
    endfunction
endpackage

// File: rtl/eag_add.sv
module eag_add #(
    parameter int W  = 16,
    parameter int PW = 8
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] off,
    output logic [W-1:0] sum,
    output logic         crossed
);
    always_comb begin
        sum     = base + off;
        crossed = (sum[W-1:PW] != base[W-1:PW]);
    end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl import eag_pkg::*; #(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode_i,
    input  logic          wr_i,
    input  logic          taken_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [1:0]    extra,
    output logic [AW-1:0] next_pc,
    output logic [AW-1:0] ia_base,
    output logic [AW-1:0] ia_off,
    input  logic [AW-1:0] ia_sum,
    input  logic          ia_cross,
    output logic [AW-1:0] ba_base,
    output logic [AW-1:0] ba_off,
    input  logic [AW-1:0] ba_sum,
    input  logic          ba_cross
);
    localparam int HW = AW - DW;

    st_t           state;
    amode_t        mode_q;
    logic          wr_q, taken_q;
    logic [AW-1:0] pc_q, ea_q, npc_q, dummy_q;
    logic [DW-1:0] lo_q, idx_q, zp_q;
    logic [1:0]    extra_q;

    logic [DW-1:0] zpa, zsum;
    logic [AW-1:0] pc_p1, pc_p2;

    always_comb begin
        pc_p1   = pc_q + AW'(1);
        pc_p2   = pc_q + AW'(2);
        zpa     = (mode_q == M_IZX) ? DW'(lo_q + idx_q) : lo_q;
        zsum    = (mode_q == M_ZP) ? rd_data : DW'(rd_data + idx_q);
        ia_base = {rd_data, lo_q};
        ia_off  = {{HW{1'b0}}, idx_q};
        ba_base = pc_p1;
        ba_off  = sext(rd_data);
        rd_en   = 1'b1;
        case (state)
            S_OPLO:  rd_addr = pc_q;
            S_OPHI:  rd_addr = pc_p1;
            S_PTRLO: rd_addr = {{HW{1'b0}}, zpa};
            S_PTRHI: rd_addr = {{HW{1'b0}}, zp_q};
            S_FIX:   rd_addr = dummy_q;
            default: begin rd_addr = '0; rd_en = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            mode_q  <= M_ABS;
            wr_q    <= 1'b0;
            taken_q <= 1'b0;
            pc_q    <= '0;
            ea_q    <= '0;
            npc_q   <= '0;
            dummy_q <= '0;
            lo_q    <= '0;
            idx_q   <= '0;
            zp_q    <= '0;
            extra_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    mode_q  <= amode_t'(mode_i);
                    wr_q    <= wr_i;
                    taken_q <= taken_i;
                    pc_q    <= pc_i;
                    idx_q   <= picks_y(amode_t'(mode_i)) ? y_i : x_i;
                    extra_q <= '0;
                    state   <= S_OPLO;
                end
                S_OPLO: begin
                    lo_q <= rd_data;
                    case (mode_q)
                        M_ZP, M_ZPX, M_ZPY: begin
                            ea_q  <= {{HW{1'b0}}, zsum};
                            npc_q <= pc_p1;
                            state <= S_DONE;
                        end
                        M_IZX, M_IZY: begin
                            npc_q <= pc_p1;
                            state <= S_PTRLO;
                        end
                        M_REL: begin
                            npc_q   <= pc_p1;
                            ea_q    <= taken_q ? ba_sum : pc_p1;
                            extra_q <= !taken_q ? 2'd0 : (ba_cross ? 2'd2 : 2'd1);
                            state   <= S_DONE;
                        end
                        default: begin
                            npc_q <= pc_p2;
                            state <= S_OPHI;
                        end
                    endcase
                end
                S_PTRLO: begin
                    lo_q  <= rd_data;
                    zp_q  <= DW'(zpa + DW'(1));
                    state <= S_PTRHI;
                end
                S_OPHI, S_PTRHI: begin
                    if (wide_indexed(mode_q)) begin
                        ea_q    <= ia_sum;
                        dummy_q <= {rd_data, ia_sum[DW-1:0]};
                        if (wr_q || ia_cross) begin
                            extra_q <= {1'b0, !wr_q && ia_cross};
                            state   <= S_FIX;
                        end else begin
                            state <= S_DONE;
                        end
                    end else begin
                        ea_q  <= {rd_data, lo_q};
                        state <= S_DONE;
                    end
                end
                S_FIX:   state <= S_DONE;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done    = (state == S_DONE);
    assign ea      = ea_q;
    assign extra   = extra_q;
    assign next_pc = npc_q;

    // R11: completion pulse lasts a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7, R8: pointer fetches stay inside page zero
    p_ptr_page_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (state == S_PTRLO || state == S_PTRHI)) |-> (rd_addr[AW-1:DW] == '0));

    // R6: zero-page modes never leave page zero
    p_zp_result_r6: assert property (@(posedge clk) disable iff (rst)
        (done && page_zero_mode(mode_q)) |-> (ea[AW-1:DW] == '0));

    // R5: write-kind indexed accesses carry no penalty
    p_write_no_penalty_r5: assert property (@(posedge clk) disable iff (rst)
        (done && wr_q && wide_indexed(mode_q)) |-> (extra == 2'd0));

    // R4: the dummy read shares its low byte with the final address
    p_dummy_low_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_FIX) |-> (rd_en && rd_addr[DW-1:0] == ea[DW-1:0]));

    // R9: only branches may report two extra cycles
    p_two_only_branch_r9: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q != M_REL) |-> (extra <= 2'd1));
endmodule

// File: rtl/ea_gen.sv
module ea_gen import eag_pkg::*; #(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic          wr_kind,
    input  logic          br_taken,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [1:0]    extra,
    output logic [AW-1:0] next_pc
);
    logic [AW-1:0] ia_base, ia_off, ia_sum;
    logic [AW-1:0] ba_base, ba_off, ba_sum;
    logic          ia_cross, ba_cross;

    eag_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode_i(mode), .wr_i(wr_kind),
        .taken_i(br_taken), .pc_i(pc), .x_i(idx_x), .y_i(idx_y),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .ea(ea), .extra(extra), .next_pc(next_pc),
        .ia_base(ia_base), .ia_off(ia_off), .ia_sum(ia_sum), .ia_cross(ia_cross),
        .ba_base(ba_base), .ba_off(ba_off), .ba_sum(ba_sum), .ba_cross(ba_cross)
    );

    eag_add #(.W(AW), .PW(DW)) u_idx_add (
        .base(ia_base), .off(ia_off), .sum(ia_sum), .crossed(ia_cross)
    );

    eag_add #(.W(AW), .PW(DW)) u_br_add (
        .base(ba_base), .off(ba_off), .sum(ba_sum), .crossed(ba_cross)
    );
endmodule

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        wr_kind = 1'b0;
    logic        br_taken = 1'b0;
    logic [15:0] pc = 16'h0;
    logic [7:0]  idx_x = 8'h0;
    logic [7:0]  idx_y = 8'h0;
    logic        rd_en, done;
    logic [15:0] rd_addr, ea, next_pc;
    logic [7:0]  rd_data;
    logic [1:0]  extra;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ea_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .wr_kind(wr_kind),
        .br_taken(br_taken), .pc(pc), .idx_x(idx_x), .idx_y(idx_y),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .ea(ea), .extra(extra), .next_pc(next_pc)
    );

    logic [15:0] ov_a [8];
    logic [7:0]  ov_d [8];
    int          ov_n = 0;

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        logic [7:0] v;
        v = a[7:0] ^ a[15:8] ^ 8'h3C;
        for (int i = 0; i < 8; i++)
            if (i < ov_n && ov_a[i] == a) v = ov_d[i];
        return v;
    endfunction

    assign rd_data = mem_rd(rd_addr);

    logic [15:0] log_a [8];
    int          log_n = 0;
    always @(negedge clk)
        if (!rst && rd_en && log_n < 8) begin
            log_a[log_n] = rd_addr;
            log_n++;
        end

    logic [15:0] r_ea, r_npc;
    logic [1:0]  r_extra;
    int          r_seen;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] d);
        ov_a[ov_n] = a;
        ov_d[ov_n] = d;
        ov_n++;
    endtask

    task automatic run_op(input logic [3:0] m, input logic w, input logic tk,
                          input logic [15:0] p, input logic [7:0] x, input logic [7:0] y);
        @(posedge clk); #1;
        log_n = 0; mode = m; wr_kind = w; br_taken = tk; pc = p; idx_x = x; idx_y = y;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        r_seen = 0;
        for (int i = 0; i < 12 && r_seen == 0; i++) begin
            @(negedge clk);
            if (done) begin
                r_seen = 1; r_ea = ea; r_extra = extra; r_npc = next_pc;
            end
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 rd_en", {31'd0, rd_en}, 32'd0);
        chk("R1 extra", {30'd0, extra}, 32'd0);
    endtask

    task automatic t_abs;
        ov_n = 0; put(16'h1234, 8'h78); put(16'h1235, 8'h56);
        run_op(4'd0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h00);
        chk("R2 done", r_seen, 1);
        chk("R2 ea", r_ea, 16'h5678);
        chk("R2 extra", r_extra, 0);
        chk("R2 next_pc", r_npc, 16'h1236);
        chk("R2 reads", log_n, 2);
        chk("R2 read0", log_a[0], 16'h1234);
        chk("R2 read1", log_a[1], 16'h1235);
    endtask

    task automatic t_idx_read;
        ov_n = 0; put(16'h0400, 8'h10); put(16'h0401, 8'h20);
        run_op(4'd1, 1'b0, 1'b0, 16'h0400, 8'h05, 8'h00);
        chk("R3 ea", r_ea, 16'h2015);
        chk("R3 extra", r_extra, 0);
        chk("R3 reads", log_n, 2);
        ov_n = 0; put(16'h0500, 8'hF0); put(16'h0501, 8'h20);
        run_op(4'd2, 1'b0, 1'b0, 16'h0500, 8'h00, 8'h20);
        chk("R4 ea", r_ea, 16'h2110);
        chk("R4 extra", r_extra, 1);
        chk("R4 reads", log_n, 3);
        chk("R4 dummy", log_a[2], 16'h2010);
    endtask

    task automatic t_idx_write;
        ov_n = 0; put(16'h0600, 8'h10); put(16'h0601, 8'h20);
        run_op(4'd1, 1'b1, 1'b0, 16'h0600, 8'h05, 8'h00);
        chk("R5 ea", r_ea, 16'h2015);
        chk("R5 extra", r_extra, 0);
        chk("R5 reads", log_n, 3);
        chk("R5 dummy", log_a[2], 16'h2015);
        ov_n = 0; put(16'h0600, 8'hF0); put(16'h0601, 8'h30);
        run_op(4'd1, 1'b1, 1'b0, 16'h0600, 8'h20, 8'h00);
        chk("R5 cross ea", r_ea, 16'h3110);
        chk("R5 cross extra", r_extra, 0);
        chk("R5 cross dummy", log_a[2], 16'h3010);
    endtask

    task automatic t_wrap;
        ov_n = 0; put(16'h0700, 8'hF0); put(16'h0701, 8'hFF);
        run_op(4'd1, 1'b0, 1'b0, 16'h0700, 8'h20, 8'h00);
        chk("R10 ea", r_ea, 16'h0010);
        chk("R10 extra", r_extra, 1);
        chk("R10 dummy", log_a[2], 16'hFF10);
    endtask

    task automatic t_zp;
        ov_n = 0; put(16'h0800, 8'h80);
        run_op(4'd3, 1'b0, 1'b0, 16'h0800, 8'h11, 8'h22);
        chk("R6 zp ea", r_ea, 16'h0080);
        chk("R6 zp reads", log_n, 1);
        chk("R6 zp next_pc", r_npc, 16'h0801);
        ov_n = 0; put(16'h0800, 8'hF0);
        run_op(4'd4, 1'b0, 1'b0, 16'h0800, 8'h20, 8'h00);
        chk("R6 zpx ea", r_ea, 16'h0010);
        ov_n = 0; put(16'h0800, 8'h7F);
        run_op(4'd5, 1'b0, 1'b0, 16'h0800, 8'h00, 8'h01);
        chk("R6 zpy ea", r_ea, 16'h0080);
    endtask

    task automatic t_izx;
        ov_n = 0; put(16'h0900, 8'hFE); put(16'h00FF, 8'h34); put(16'h0000, 8'h12);
        run_op(4'd6, 1'b0, 1'b0, 16'h0900, 8'h01, 8'h00);
        chk("R7 reads", log_n, 3);
        chk("R7 ptr lo", log_a[1], 16'h00FF);
        chk("R7 ptr hi", log_a[2], 16'h0000);
        chk("R7 ea", r_ea, 16'h1234);
        chk("R7 extra", r_extra, 0);
        chk("R7 next_pc", r_npc, 16'h0901);
    endtask

    task automatic t_izy;
        ov_n = 0; put(16'h0A00, 8'hFF); put(16'h00FF, 8'hF0); put(16'h0000, 8'h12);
        run_op(4'd7, 1'b0, 1'b0, 16'h0A00, 8'h00, 8'h20);
        chk("R8 reads", log_n, 4);
        chk("R8 ptr lo", log_a[1], 16'h00FF);
        chk("R8 ptr hi", log_a[2], 16'h0000);
        chk("R8 dummy", log_a[3], 16'h1210);
        chk("R8 ea", r_ea, 16'h1310);
        chk("R8 extra", r_extra, 1);
        run_op(4'd7, 1'b1, 1'b0, 16'h0A00, 8'h00, 8'h05);
        chk("R8 write dummy", log_a[3], 16'h12F5);
        chk("R8 write ea", r_ea, 16'h12F5);
        chk("R8 write extra", r_extra, 0);
    endtask

    task automatic t_rel;
        ov_n = 0; put(16'h2100, 8'h80); put(16'h2200, 8'h10);
        put(16'h20F0, 8'h20); put(16'hFFFE, 8'h05);
        run_op(4'd8, 1'b1, 1'b1, 16'h2100, 8'h00, 8'h00);
        chk("R9 back ea", r_ea, 16'h2081);
        chk("R9 back extra", r_extra, 2);
        chk("R9 reads", log_n, 1);
        chk("R9 next_pc", r_npc, 16'h2101);
        run_op(4'd8, 1'b0, 1'b0, 16'h2200, 8'h00, 8'h00);
        chk("R9 not taken ea", r_ea, 16'h2201);
        chk("R9 not taken extra", r_extra, 0);
        run_op(4'd8, 1'b0, 1'b1, 16'h2200, 8'h00, 8'h00);
        chk("R9 same page ea", r_ea, 16'h2211);
        chk("R9 same page extra", r_extra, 1);
        run_op(4'd8, 1'b0, 1'b1, 16'h20F0, 8'h00, 8'h00);
        chk("R9 fwd ea", r_ea, 16'h2111);
        chk("R9 fwd extra", r_extra, 2);
        run_op(4'd8, 1'b0, 1'b1, 16'hFFFE, 8'h00, 8'h00);
        chk("R10 branch wrap ea", r_ea, 16'h0004);
        chk("R10 branch wrap extra", r_extra, 2);
    endtask

    task automatic t_busy;
        int dones;
        ov_n = 0; put(16'h3000, 8'hCD); put(16'h3001, 8'hAB);
        @(posedge clk); #1;
        log_n = 0; mode = 4'd0; wr_kind = 1'b0; pc = 16'h3000; start = 1'b1;
        @(posedge clk); #1;
        mode = 4'd3; pc = 16'h3001;
        dones = 0;
        @(negedge clk); if (done) begin dones++; r_ea = ea; end
        @(negedge clk); if (done) begin dones++; r_ea = ea; end
        @(posedge clk); #1;
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (done) begin dones++; r_ea = ea; end
        end
        chk("R11 one done", dones, 1);
        chk("R11 ea", r_ea, 16'hABCD);
        chk("R11 reads", log_n, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_abs();
        t_idx_read();
        t_idx_write();
        t_wrap();
        t_zp();
        t_izx();
        t_izy();
        t_rel();
        t_busy();
        repeat (2) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule